// File: doc/BRIEF.md
# Multi-Entry Ternary Flow Classifier

The block sits inline on a 32-bit packet word stream. It pulls a 112-bit lookup key out of the first four words of each packet and compares that key against a small bank of ternary entries. Each entry holds a value, a care mask and a 16-bit flow identifier. The block reports which entries hit, picks the flow identifier of the hitting entry with the lowest index, and folds the key into a 16-bit XOR hash. The packet words pass through a fixed five-stage delay line, so all three results are already present when the first word of the packet leaves.

The entries are loaded through a write port that addresses a single entry by its index. The port loads the value, mask, flow identifier and an enable bit of that entry in one cycle. A downstream queueing stage samples the flow identifier or the hash on the cycle its start-of-packet flag is high.

Top module: `flow_classifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, valid_o, sop_o, eop_o, match_o, flow_id_o and flow_hash_o are all zero.
- R2: Every input word appears on data_o with valid_o, sop_o and eop_o unchanged, exactly 5 clock cycles after it is sampled. The delay does not depend on gaps in the stream.
- R3: The four header words arrive on consecutive valid cycles, starting with the sop word. Word 0 is the source address. Word 1 is the destination address. Word 2 holds the source port in [31:16] and the destination port in [15:0]. Word 3 holds the protocol in [31:24], and its bits [23:0] are ignored. The key is {src, dst, sport, dport, proto, 8'h00}, which puts the protocol in key[15:8]. Packets are at least 4 words long.
- R4: match_o[i] is 1 when entry i is enabled and ((key ^ value_i) & mask_i) is zero. A mask bit of 1 means that key bit is compared.
- R5: When several entries match, flow_id_o is the flow identifier of the matching entry with the lowest index.
- R6: When no entry matches, match_o is 0 and flow_id_o is 0.
- R7: flow_hash_o is the XOR of the seven 16-bit slices key[16k+15:16k], for k = 0..6.
- R8: match_o, flow_id_o and flow_hash_o belong to a packet on the cycle its sop_o is high. They hold their values until the next packet's key has been classified.
- R9: A write with wr_en_i high loads the enable, value, mask and flow identifier of entry wr_idx_i and leaves every other entry unchanged. The new contents are used for every packet whose last header word comes after the write edge.
- R10: An entry written with wr_vld_i low never matches, whatever its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Packet word in |
| valid_i | input | 1 | Input word valid |
| sop_i | input | 1 | First word of packet |
| eop_i | input | 1 | Last word of packet |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 2 | Entry index to write |
| wr_vld_i | input | 1 | Enable bit for the written entry |
| wr_val_i | input | 112 | Entry compare value |
| wr_msk_i | input | 112 | Entry care mask, 1 = compare |
| wr_fid_i | input | 16 | Entry flow identifier |
| data_o | output | 32 | Delayed packet word |
| valid_o | output | 1 | Delayed valid |
| sop_o | output | 1 | Delayed start of packet |
| eop_o | output | 1 | Delayed end of packet |
| match_o | output | 4 | Per-entry hit vector |
| flow_id_o | output | 16 | Flow identifier of the winning entry |
| flow_hash_o | output | 16 | XOR-folded key hash |

## Verification
Some properties are checked on every cycle. The delay line keeps the five-cycle relation between input and output flags. A start-of-packet on the output always follows a fresh classification. The results never change between classifications, and an empty hit vector always comes with a zero flow identifier. Other behaviour can only be shown by the bench's scenarios. These include correct key extraction, ternary compare, lowest-index priority, hash folding, indexed rewrites and disabled entries. The bench sweeps protocol and port fields against overlapping masks and checks every packet against an arithmetic model.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned FC_WORD_W   = 32;
  localparam int unsigned FC_HDR_WDS  = 4;
  localparam int unsigned FC_KEY_W    = 112;
  localparam int unsigned FC_PROTO_W  = 8;
  localparam int unsigned FC_LAT      = FC_HDR_WDS + 1;

  typedef struct packed {
    logic                 vld;
    logic                 sop;
    logic                 eop;
    logic [FC_WORD_W-1:0] data;
  } fc_word_t;
endpackage

// File: rtl/fc_hdr_extract.sv
module fc_hdr_extract
  import fc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sop_i,
  input  logic [FC_WORD_W-1:0] data_i,
  output logic [FC_KEY_W-1:0]  key_o,
  output logic                 key_vld_o
);
  localparam int unsigned CNT_W = $clog2(FC_HDR_WDS);
  localparam int unsigned PAD_W = FC_KEY_W - 3*FC_WORD_W - FC_PROTO_W;

  logic [CNT_W-1:0]     cnt_q;
  logic                 busy_q;
  logic [FC_WORD_W-1:0] w0_q, w1_q, w2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      w0_q      <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      key_o     <= '0;
      key_vld_o <= 1'b0;
    end else begin
      key_vld_o <= 1'b0;
      if (valid_i && sop_i) begin
        w0_q   <= data_i;
        cnt_q  <= CNT_W'(1);
        busy_q <= 1'b1;
      end else if (valid_i && busy_q) begin
        unique case (cnt_q)
          CNT_W'(1): w1_q <= data_i;
          CNT_W'(2): w2_q <= data_i;
          default: begin
            key_o     <= {w0_q, w1_q, w2_q,
                          data_i[FC_WORD_W-1 -: FC_PROTO_W], {PAD_W{1'b0}}};
            key_vld_o <= 1'b1;
            busy_q    <= 1'b0;
          end
        endcase
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fc_cam_bank.sv
module fc_cam_bank
  import fc_pkg::*;
#(
  parameter int unsigned N_ENTRY = 4,
  parameter int unsigned FID_W   = 16,
  localparam int unsigned IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_vld_i,
  input  logic [FC_KEY_W-1:0] wr_val_i,
  input  logic [FC_KEY_W-1:0] wr_msk_i,
  input  logic [FID_W-1:0]    wr_fid_i,
  input  logic [FC_KEY_W-1:0] key_i,
  output logic [N_ENTRY-1:0]  hit_o,
  output logic [FID_W-1:0]    fid_o [N_ENTRY]
);
  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    logic                vld_q;
    logic [FC_KEY_W-1:0] val_q, msk_q;
    logic [FID_W-1:0]    fid_q;
    logic                sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        val_q <= '0;
        msk_q <= '0;
        fid_q <= '0;
      end else if (sel) begin
        vld_q <= wr_vld_i;
        val_q <= wr_val_i;
        msk_q <= wr_msk_i;
        fid_q <= wr_fid_i;
      end
    end

    assign hit_o[g] = vld_q && (((key_i ^ val_q) & msk_q) == '0);
    assign fid_o[g] = fid_q;
  end
endmodule

// File: rtl/fc_prio_sel.sv
module fc_prio_sel #(
  parameter int unsigned N_ENTRY = 4,
  parameter int unsigned FID_W   = 16
) (
  input  logic [N_ENTRY-1:0] hit_i,
  input  logic [FID_W-1:0]   fid_i [N_ENTRY],
  output logic [FID_W-1:0]   fid_o
);
  // scan high to low so the lowest hitting index is written last
  always_comb begin
    fid_o = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (hit_i[i]) fid_o = fid_i[i];
    end
  end
endmodule

// File: rtl/fc_hash_fold.sv
module fc_hash_fold
  import fc_pkg::*;
#(
  parameter int unsigned HASH_W = 16,
  localparam int unsigned N_SLICE = FC_KEY_W / HASH_W
) (
  input  logic [FC_KEY_W-1:0] key_i,
  output logic [HASH_W-1:0]   hash_o
);
  always_comb begin
    hash_o = '0;
    for (int k = 0; k < N_SLICE; k++) hash_o ^= key_i[k*HASH_W +: HASH_W];
  end
endmodule

// File: rtl/fc_word_delay.sv
module fc_word_delay
  import fc_pkg::*;
#(
  parameter int unsigned DEPTH = FC_LAT
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fc_word_t word_i,
  output fc_word_t word_o
);
  fc_word_t stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= word_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign word_o = stg_q[DEPTH-1];
endmodule

// File: rtl/flow_classifier.sv
module flow_classifier
  import fc_pkg::*;
#(
  parameter int unsigned N_ENTRY = 4,
  parameter int unsigned FID_W   = 16,
  parameter int unsigned HASH_W  = 16,
  localparam int unsigned IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [FC_WORD_W-1:0] data_i,
  input  logic                 valid_i,
  input  logic                 sop_i,
  input  logic                 eop_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic                 wr_vld_i,
  input  logic [FC_KEY_W-1:0]  wr_val_i,
  input  logic [FC_KEY_W-1:0]  wr_msk_i,
  input  logic [FID_W-1:0]     wr_fid_i,
  output logic [FC_WORD_W-1:0] data_o,
  output logic                 valid_o,
  output logic                 sop_o,
  output logic                 eop_o,
  output logic [N_ENTRY-1:0]   match_o,
  output logic [FID_W-1:0]     flow_id_o,
  output logic [HASH_W-1:0]    flow_hash_o
);
  logic [FC_KEY_W-1:0] key;
  logic                key_vld;
  logic [N_ENTRY-1:0]  hit;
  logic [FID_W-1:0]    ent_fid [N_ENTRY];
  logic [FID_W-1:0]    win_fid;
  logic [HASH_W-1:0]   hash;
  fc_word_t            win, wout;

  fc_hdr_extract i_extract (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .sop_i     (sop_i),
    .data_i    (data_i),
    .key_o     (key),
    .key_vld_o (key_vld)
  );

  fc_cam_bank #(.N_ENTRY(N_ENTRY), .FID_W(FID_W)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_vld_i (wr_vld_i),
    .wr_val_i (wr_val_i),
    .wr_msk_i (wr_msk_i),
    .wr_fid_i (wr_fid_i),
    .key_i    (key),
    .hit_o    (hit),
    .fid_o    (ent_fid)
  );

  fc_prio_sel #(.N_ENTRY(N_ENTRY), .FID_W(FID_W)) i_prio (
    .hit_i (hit),
    .fid_i (ent_fid),
    .fid_o (win_fid)
  );

  fc_hash_fold #(.HASH_W(HASH_W)) i_hash (
    .key_i  (key),
    .hash_o (hash)
  );

  // result registers load one cycle after the key, i.e. on the edge
  // that moves the sop word into the last delay stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o     <= '0;
      flow_id_o   <= '0;
      flow_hash_o <= '0;
    end else if (key_vld) begin
      match_o     <= hit;
      flow_id_o   <= win_fid;
      flow_hash_o <= hash;
    end
  end

  assign win = '{vld: valid_i, sop: sop_i, eop: eop_i, data: data_i};

  fc_word_delay #(.DEPTH(FC_LAT)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (win),
    .word_o (wout)
  );

  assign data_o  = wout.data;
  assign valid_o = wout.vld;
  assign sop_o   = wout.sop;
  assign eop_o   = wout.eop;
endmodule

// File: rtl/fc_classifier_chk.sv
module fc_classifier_chk #(
  parameter int unsigned N_ENTRY = 4,
  parameter int unsigned FID_W   = 16,
  parameter int unsigned HASH_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               sop_i,
  input logic               eop_i,
  input logic               valid_o,
  input logic               sop_o,
  input logic               eop_o,
  input logic               key_vld,
  input logic [N_ENTRY-1:0] match_o,
  input logic [FID_W-1:0]   flow_id_o,
  input logic [HASH_W-1:0]  flow_hash_o
);
  logic [3:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 4'hF) age_q <= age_q + 4'd1;
  end

  AST_FLAG_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 4'd6) |-> ({valid_o, sop_o, eop_o} == $past({valid_i, sop_i, eop_i}, 5))); // R2
  AST_SOP_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> valid_o); // R2
  AST_SOP_FRESH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> $past(key_vld)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_vld |=> ($stable(match_o) && $stable(flow_id_o) && $stable(flow_hash_o))); // R8
  AST_NO_HIT_ZERO_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o == '0) |-> (flow_id_o == '0)); // R6
endmodule

bind flow_classifier fc_classifier_chk #(
  .N_ENTRY(N_ENTRY), .FID_W(FID_W), .HASH_W(HASH_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .sop_i       (sop_i),
  .eop_i       (eop_i),
  .valid_o     (valid_o),
  .sop_o       (sop_o),
  .eop_o       (eop_o),
  .key_vld     (key_vld),
  .match_o     (match_o),
  .flow_id_o   (flow_id_o),
  .flow_hash_o (flow_hash_o)
);

// File: tb/test_flow_classifier.sv
`timescale 1ns/1ps
module test_flow_classifier;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  data_i = '0;
  logic         valid_i = 1'b0, sop_i = 1'b0, eop_i = 1'b0;
  logic         wr_en_i = 1'b0, wr_vld_i = 1'b0;
  logic [1:0]   wr_idx_i = '0;
  logic [111:0] wr_val_i = '0, wr_msk_i = '0;
  logic [15:0]  wr_fid_i = '0;
  logic [31:0]  data_o;
  logic         valid_o, sop_o, eop_o;
  logic [3:0]   match_o;
  logic [15:0]  flow_id_o, flow_hash_o;

  always #4 clk = ~clk;

  flow_classifier i_flow_classifier (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .valid_i(valid_i),
    .sop_i(sop_i), .eop_i(eop_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_vld_i(wr_vld_i), .wr_val_i(wr_val_i), .wr_msk_i(wr_msk_i),
    .wr_fid_i(wr_fid_i), .data_o(data_o), .valid_o(valid_o), .sop_o(sop_o),
    .eop_o(eop_o), .match_o(match_o), .flow_id_o(flow_id_o),
    .flow_hash_o(flow_hash_o)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit mon_on = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference entry model
  bit           m_vld [4];
  logic [111:0] m_val [4], m_msk [4];
  logic [15:0]  m_fid [4];

  // expected streams
  logic [31:0] ew_data [4096];
  bit          ew_sop [4096], ew_eop [4096];
  int          ew_wr = 0, ew_rd = 0;
  logic [3:0]  ep_match [1024];
  logic [15:0] ep_fid [1024], ep_hash [1024];
  int          ep_cyc [1024];
  int          ep_wr = 0, ep_rd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_entry(input int idx, input bit v, input logic [111:0] val,
                          input logic [111:0] msk, input logic [15:0] fid);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_vld_i = v;
    wr_val_i = val; wr_msk_i = msk; wr_fid_i = fid;
    m_vld[idx] = v; m_val[idx] = val; m_msk[idx] = msk; m_fid[idx] = fid;
    @(negedge clk);
    wr_en_i = 1'b0; wr_val_i = '1; wr_msk_i = '0; wr_fid_i = 16'hDEAD;
  endtask

  task automatic send_pkt(input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] sp, input logic [15:0] dp,
                          input logic [7:0] pr, input int len, input int gap);
    logic [111:0] key;
    logic [15:0]  h, fid;
    logic [3:0]   m;
    logic [31:0]  w;
    key = {s, d, sp, dp, pr, 8'h00};           // R3 layout
    h = '0;
    for (int k = 0; k < 7; k++) h ^= key[k*16 +: 16];  // R7
    m = '0; fid = '0;
    for (int i = 0; i < 4; i++)
      m[i] = m_vld[i] && (((key ^ m_val[i]) & m_msk[i]) == '0);  // R4 R10
    for (int i = 3; i >= 0; i--) if (m[i]) fid = m_fid[i];       // R5 R6
    ep_match[ep_wr % 1024] = m;
    ep_fid[ep_wr % 1024]   = fid;
    ep_hash[ep_wr % 1024]  = h;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      case (k)
        0: w = s;
        1: w = d;
        2: w = {sp, dp};
        3: w = {pr, 24'(ep_wr * 32'h9E3779)};  // low bits must be ignored
        default: w = {16'(ep_wr), 16'(k)};
      endcase
      if (k == 0) begin
        ep_cyc[ep_wr % 1024] = cyc;
        ep_wr++;
      end
      data_i = w; valid_i = 1'b1; sop_i = (k == 0); eop_i = (k == len - 1);
      ew_data[ew_wr % 4096] = w;
      ew_sop[ew_wr % 4096]  = (k == 0);
      ew_eop[ew_wr % 4096]  = (k == len - 1);
      ew_wr++;
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      valid_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0; data_i = 32'hBAD0BAD0;
    end
  endtask

  task automatic idle(input int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      valid_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_on && valid_o) begin
      chk(ew_rd < ew_wr, "R2", "unexpected word", 128'(data_o), 0);
      if (ew_rd < ew_wr) begin
        chk(data_o == ew_data[ew_rd % 4096], "R2", "data_o",
            128'(data_o), 128'(ew_data[ew_rd % 4096]));
        chk({sop_o, eop_o} == {ew_sop[ew_rd % 4096], ew_eop[ew_rd % 4096]},
            "R2", "sop/eop", 128'({sop_o, eop_o}),
            128'({ew_sop[ew_rd % 4096], ew_eop[ew_rd % 4096]}));
        ew_rd++;
      end
      if (sop_o && ep_rd < ep_wr) begin
        chk(cyc - ep_cyc[ep_rd % 1024] == 5, "R2", "latency",
            128'(cyc - ep_cyc[ep_rd % 1024]), 128'(5));
        chk(match_o == ep_match[ep_rd % 1024], "R4", "match_o",
            128'(match_o), 128'(ep_match[ep_rd % 1024]));
        chk(flow_id_o == ep_fid[ep_rd % 1024], "R5", "flow_id_o",
            128'(flow_id_o), 128'(ep_fid[ep_rd % 1024]));
        chk(flow_hash_o == ep_hash[ep_rd % 1024], "R7", "flow_hash_o",
            128'(flow_hash_o), 128'(ep_hash[ep_rd % 1024]));
        ep_rd++;
      end else if (eop_o && ep_rd > 0) begin
        // results still held for the packet on its last word
        chk(flow_id_o == ep_fid[(ep_rd - 1) % 1024], "R8", "flow_id_o held",
            128'(flow_id_o), 128'(ep_fid[(ep_rd - 1) % 1024]));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_vld[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0; m_fid[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk({valid_o, sop_o, eop_o, match_o, flow_id_o, flow_hash_o} == '0, "R1",
        "outputs in reset", 128'({valid_o, match_o, flow_id_o, flow_hash_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({valid_o, sop_o, eop_o, match_o, flow_id_o, flow_hash_o} == '0, "R1",
        "outputs after reset", 128'({valid_o, match_o, flow_id_o, flow_hash_o}), 0);
    mon_on = 1'b1;

    // R9: overlapping ternary entries, entry 3 is a wildcard
    wr_entry(0, 1, 112'h06 << 8,  112'hFF << 8,  16'h1001);              // proto == 6
    wr_entry(1, 1, 112'h5 << 16,  112'hF << 16,  16'h2002);              // dport[3:0] == 5
    wr_entry(2, 1, 112'h1 << 16, (112'h3 << 16) | (112'h1 << 8), 16'h3003);
    wr_entry(3, 1, '1,            '0,            16'h4004);

    // phase A: full sweep of proto[3:0] x dport[3:0], mixed lengths and gaps
    for (int pr = 0; pr < 16; pr++)
      for (int dl = 0; dl < 16; dl++)
        send_pkt(32'hC0A80000 | 32'((pr << 4) | dl), 32'((pr * 7 + 1) * 32'h01010101),
                 16'(pr * 4099), 16'((dl * 16'h1110) | dl), 8'(pr),
                 4 + (pr + dl) % 3, (dl % 3 == 0) ? 0 : dl % 2);
    idle(10);

    // phase B (R10, R6): entry 3 disabled, its all-zero mask must not hit
    wr_entry(3, 0, '0, '0, 16'h7777);
    for (int pr = 0; pr < 8; pr++)
      for (int dl = 0; dl < 8; dl++)
        send_pkt(32'h0A000001 + 32'(pr), 32'hFFFF0000 | 32'(dl), 16'(dl * 3),
                 16'(dl), 8'(pr), 4, pr % 2);
    idle(10);

    // phase C (R9): rewrite entry 0 only by index to an exact source match
    wr_entry(0, 1, 112'hC0A81E0D << 80, 112'hFFFFFFFF << 80, 16'hBEEF);
    for (int i = 0; i < 32; i++)
      send_pkt((i % 2) ? 32'hC0A81E0D : 32'hC0A81E0C, 32'(i * 32'h10203),
               16'(i), 16'(i), 8'(6 + (i % 3)), 4 + i % 2, 0);
    idle(10);

    chk(ep_rd == ep_wr, "R8", "packets seen", 128'(ep_rd), 128'(ep_wr));
    chk(ew_rd == ew_wr, "R2", "words seen", 128'(ew_rd), 128'(ew_wr));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule